// File: doc/BRIEF.md
# Qualified Write Strobe Capture

This block sits between the asynchronous bus pins of a memory-like device and its command decoder. It samples the active-low chip-enable, write-enable and output-enable strobes, the address bus, the data bus, a supply-good flag and an active-low device reset pin, all on a fast system clock. It turns the strobe activity into clean write events. Each event is a single-clock `wr_valid` pulse that carries the address and data of that bus write.

A bus write exists only while both enables are low and output-enable is high. The address is taken when that condition begins, which is the falling edge of whichever enable went low last. The data is the last value seen before the condition ends, which is the first rising edge of either enable. Short strobe pulses are rejected by a minimum-width filter set in clock cycles.

Writes are also refused in three cases: while the supply has not been good for a holdoff count of cycles, while the device reset pin is low, and while output-enable is low. Any cycle cut short by one of these produces no event. A new cycle can then start only after an enable has gone high again.

Top module: `wr_strobe_qualifier`

## Requirements
- R1: After the system reset `rst_n` is released, `wr_valid` is 0 and `wr_addr` and `wr_data` are all zeros until the first write event.
- R2: A write event is emitted only for a bus cycle in which `ce_n` and `we_n` are both low while `oe_n` is high. The cycle ends when either enable goes high.
- R3: The event address is the `addr_in` value present when the second of the two enables falls. Later address changes within the cycle do not alter it.
- R4: The event data is the `data_in` value present in the last sampled clock in which both enables were low. Data driven at or after the first enable rising edge is not used.
- R5: A cycle whose both-low time is shorter than `GLITCH_CYC` clocks produces no event. A cycle of exactly `GLITCH_CYC` clocks produces one event.
- R6: `oe_n` low inhibits writes. A cycle during which `oe_n` is low from the start, or falls partway through, produces no event.
- R7: After `supply_ok` rises, writes are refused until it has stayed high for `HOLDOFF_CYC` clocks. A drop of `supply_ok` restarts the holdoff.
- R8: `hw_rst_n` low aborts the cycle in progress and blocks writes. After an abort of any kind, no event is produced until one of the enables has returned high and a fresh cycle starts.
- R9: `wr_valid` is high in the third clock edge after the enable rising edge that ends a qualifying cycle. This latency is two synchroniser stages plus one output register.
- R10: `wr_valid` is high for exactly one clock per bus write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset of all flops |
| hw_rst_n | input | 1 | Asynchronous active-low device reset pin |
| supply_ok | input | 1 | Asynchronous supply-good indication |
| ce_n | input | 1 | Asynchronous active-low chip enable |
| we_n | input | 1 | Asynchronous active-low write enable |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr_in | input | AW | Address bus pins |
| data_in | input | DW | Data bus pins |
| wr_valid | output | 1 | One-clock write event strobe |
| wr_addr | output | AW | Address of the latest write event |
| wr_data | output | DW | Data of the latest write event |

## Verification
On every cycle, the assertions enforce a set of event rules. An event is never longer than one clock. It never follows a clock in which output-enable was low or writes were not permitted. It never follows a cycle that was shorter than the glitch window. It never appears in the clock after the reset pin was seen low. The holdoff flag also clears as soon as the supply flag drops. Only the directed scenarios can show the remaining behaviour: which address and data are picked from changing buses when the enables move in either order, the exact width threshold of the filter, the full holdoff length and its restart, and the latency from the enable edge to the pulse.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

    // Capture sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for both enables to fall while qualified
        ST_CAPT  = 2'd1,   // inside a qualified write cycle
        ST_BLOCK = 2'd2    // aborted or unqualified, wait for an enable to rise
    } wsq_state_e;

endpackage

// File: rtl/wsq_sync2.sv
// Two-stage sampling pipeline. Used as a metastability synchroniser for
// single strobes and as a matching delay line for the buses so that bus
// values stay aligned with the synchronised strobes.
module wsq_sync2 #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/wsq_holdoff.sv
// Power-up holdoff: done rises once supply has been good for HOLDOFF_CYC clocks.
module wsq_holdoff #(
    parameter int HOLDOFF_CYC = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_s,
    output logic done
);
    localparam int HW = (HOLDOFF_CYC < 2) ? 1 : $clog2(HOLDOFF_CYC + 1);
    localparam logic [HW-1:0] LIMIT = HW'(HOLDOFF_CYC);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          done;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!supply_s) begin
            h_d.cnt  = '0;
            h_d.done = 1'b0;
        end else if (h_q.cnt == LIMIT) begin
            h_d.done = 1'b1;
        end else begin
            h_d.cnt = h_q.cnt + HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign done = h_q.done;

    // R7
    supply_drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_s |=> !done);

    // R7
    done_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(supply_s));
endmodule

// File: rtl/wsq_tracker.sv
// Write cycle sequencer working on synchronised strobes and aligned buses.
module wsq_tracker
    import wsq_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 16,
    parameter int GLITCH_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          we_s,
    input  logic          oe_s,
    input  logic          permit,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          vld,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] GMAX = CW'(GLITCH_CYC);

    typedef struct packed {
        wsq_state_e    st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          vld;
        logic [AW-1:0] o_addr;
        logic [DW-1:0] o_data;
    } trk_t;

    trk_t t_d, t_q;
    logic both_low;
    logic qualified;
    logic clean_end;

    always_comb begin
        both_low  = ~ce_s & ~we_s;
        qualified = both_low & oe_s & permit;
        clean_end = ~both_low & oe_s & permit;

        t_d     = t_q;
        t_d.vld = 1'b0;

        unique case (t_q.st)
            ST_IDLE: begin
                if (qualified) begin
                    t_d.st   = ST_CAPT;
                    t_d.cnt  = CW'(1);
                    t_d.addr = addr_s;
                    t_d.data = data_s;
                end else if (both_low) begin
                    t_d.st = ST_BLOCK;
                end
            end
            ST_CAPT: begin
                if (qualified) begin
                    if (t_q.cnt != GMAX) begin
                        t_d.cnt = t_q.cnt + CW'(1);
                    end
                    t_d.data = data_s;
                end else if (clean_end) begin
                    t_d.st = ST_IDLE;
                    if (t_q.cnt >= GMAX) begin
                        t_d.vld    = 1'b1;
                        t_d.o_addr = t_q.addr;
                        t_d.o_data = t_q.data;
                    end
                end else begin
                    t_d.st = both_low ? ST_BLOCK : ST_IDLE;
                end
            end
            ST_BLOCK: begin
                if (!both_low) begin
                    t_d.st = ST_IDLE;
                end
            end
            default: t_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{st: ST_IDLE, default: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign vld      = t_q.vld;
    assign out_addr = t_q.o_addr;
    assign out_data = t_q.o_data;

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    // R6
    oe_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(oe_s && permit));

    // R5
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(t_q.cnt >= GMAX));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == ST_CAPT && qualified) |=> $stable(t_q.addr));

    // R2
    end_by_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(ce_s || we_s));
endmodule

// File: rtl/wr_strobe_qualifier.sv
module wr_strobe_qualifier #(
    parameter int AW          = 19,
    parameter int DW          = 16,
    parameter int GLITCH_CYC  = 2,
    parameter int HOLDOFF_CYC = 1250000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_rst_n,
    input  logic          supply_ok,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int NCTL = 5;
    localparam int BW   = AW + DW;
    // idle values: enables high, supply and device reset pin low
    localparam logic [NCTL-1:0] CTL_IDLE = 5'b11100;

    logic [NCTL-1:0] ctl_s;
    logic [BW-1:0]   bus_s;
    logic            ce_s, we_s, oe_s, supply_s, hwrst_s;
    logic            hold_done;
    logic            permit;

    wsq_sync2 #(.WIDTH(NCTL), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ce_n, we_n, oe_n, supply_ok, hw_rst_n}),
        .dout (ctl_s)
    );

    wsq_sync2 #(.WIDTH(BW), .RST_VAL('0)) u_bus_align (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({addr_in, data_in}),
        .dout (bus_s)
    );

    assign {ce_s, we_s, oe_s, supply_s, hwrst_s} = ctl_s;

    wsq_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_holdoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .supply_s(supply_s),
        .done    (hold_done)
    );

    assign permit = hold_done & hwrst_s;

    wsq_tracker #(.AW(AW), .DW(DW), .GLITCH_CYC(GLITCH_CYC)) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (ce_s),
        .we_s    (we_s),
        .oe_s    (oe_s),
        .permit  (permit),
        .addr_s  (bus_s[BW-1:DW]),
        .data_s  (bus_s[DW-1:0]),
        .vld     (wr_valid),
        .out_addr(wr_addr),
        .out_data(wr_data)
    );

    // R8
    hw_reset_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hwrst_s |=> !wr_valid);

    // R7
    holdoff_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(hold_done));
endmodule

// File: tb/tb_wr_strobe_qualifier.sv
`timescale 1ns/1ps
module tb_wr_strobe_qualifier;
    localparam int AW = 19;
    localparam int DW = 16;
    localparam int GW = 2;
    localparam int HO = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_rst_n = 1'b1;
    logic          supply_ok = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk = 0, n_err = 0, pulses = 0, base = 0;
    logic [AW-1:0] last_a;
    logic [DW-1:0] last_d;

    wr_strobe_qualifier #(.AW(AW), .DW(DW), .GLITCH_CYC(GW), .HOLDOFF_CYC(HO)) dut (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .supply_ok(supply_ok),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr_in(addr_in), .data_in(data_in),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            pulses = pulses + 1;
            last_a = wr_addr;
            last_d = wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_events(input string req, input int n, input logic [AW-1:0] a,
                                 input logic [DW-1:0] d);
        idle(6);
        chk(pulses - base == n, req, pulses - base, n);
        if (n > 0) begin
            chk(last_a == a, {req, " addr"}, last_a, a);
            chk(last_d == d, {req, " data"}, last_d, d);
        end
        base = pulses;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int w);
        @(negedge clk);
        addr_in = a; data_in = d; ce_n = 1'b0; we_n = 1'b0;
        idle(w);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic t_reset;
        idle(3);
        // R1: quiet outputs after system reset
        chk(wr_valid == 1'b0, "R1 valid", wr_valid, 0);
        chk(wr_addr == '0, "R1 addr", wr_addr, 0);
        chk(wr_data == '0, "R1 data", wr_data, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        chk(wr_valid == 1'b0, "R1 valid after release", wr_valid, 0);
    endtask

    task automatic t_holdoff;
        @(negedge clk); supply_ok = 1'b1;
        idle(5);
        bus_write(19'h01234, 16'h1111, 4);
        expect_events("R7 early write refused", 0, 0, 0);
        idle(HO);
        bus_write(19'h05555, 16'h00AA, 4);
        expect_events("R2 basic write", 1, 19'h05555, 16'h00AA);
        // supply drop restarts holdoff
        @(negedge clk); supply_ok = 1'b0;
        idle(5);
        supply_ok = 1'b1;
        idle(3);
        bus_write(19'h02AAA, 16'h0055, 4);
        expect_events("R7 refused after supply drop", 0, 0, 0);
        idle(HO);
        bus_write(19'h02AAA, 16'h0055, 4);
        expect_events("R7 accepted after new holdoff", 1, 19'h02AAA, 16'h0055);
    endtask

    task automatic t_latency;
        @(negedge clk);
        addr_in = 19'h7E000; data_in = 16'hBEEF; ce_n = 1'b0; we_n = 1'b0;
        idle(3);
        we_n = 1'b1;
        @(negedge clk); chk(wr_valid == 1'b0, "R9 edge+1", wr_valid, 0);
        ce_n = 1'b1;
        @(negedge clk); chk(wr_valid == 1'b0, "R9 edge+2", wr_valid, 0);
        @(negedge clk); chk(wr_valid == 1'b1, "R9 edge+3", wr_valid, 1);
        @(negedge clk); chk(wr_valid == 1'b0, "R10 one clock", wr_valid, 0);
        expect_events("R10 single event", 1, 19'h7E000, 16'hBEEF);
    endtask

    task automatic t_addr_order;
        // write-enable first, chip-enable last
        @(negedge clk); addr_in = 19'h00111; we_n = 1'b0; data_in = 16'h0001;
        @(negedge clk); addr_in = 19'h00222; ce_n = 1'b0;
        @(negedge clk); addr_in = 19'h00333;
        idle(2);
        ce_n = 1'b1; we_n = 1'b1;
        expect_events("R3 ce falls last", 1, 19'h00222, 16'h0001);
        // chip-enable first, write-enable last
        @(negedge clk); addr_in = 19'h00444; ce_n = 1'b0; data_in = 16'h0002;
        idle(2);
        addr_in = 19'h00555; we_n = 1'b0;
        @(negedge clk); addr_in = 19'h00666;
        idle(2);
        ce_n = 1'b1; we_n = 1'b1;
        expect_events("R3 we falls last", 1, 19'h00555, 16'h0002);
    endtask

    task automatic t_data;
        @(negedge clk); addr_in = 19'h10000; data_in = 16'hD000; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        data_in = 16'hD111;
        idle(2);
        ce_n = 1'b1; data_in = 16'hD222;
        idle(2);
        we_n = 1'b1;
        expect_events("R4 data before first rise", 1, 19'h10000, 16'hD111);
    endtask

    task automatic t_glitch;
        bus_write(19'h20000, 16'h0A0A, 1);
        expect_events("R5 short pulse rejected", 0, 0, 0);
        bus_write(19'h20001, 16'h0B0B, GW);
        expect_events("R5 window-width pulse accepted", 1, 19'h20001, 16'h0B0B);
    endtask

    task automatic t_oe;
        @(negedge clk); oe_n = 1'b0;
        bus_write(19'h30000, 16'h0C0C, 4);
        @(negedge clk); oe_n = 1'b1;
        expect_events("R6 oe low throughout", 0, 0, 0);
        @(negedge clk); addr_in = 19'h30001; ce_n = 1'b0; we_n = 1'b0;
        idle(3);
        oe_n = 1'b0;
        idle(2);
        oe_n = 1'b1;
        idle(3);
        ce_n = 1'b1; we_n = 1'b1;
        expect_events("R6 oe falls mid-cycle", 0, 0, 0);
    endtask

    task automatic t_hwreset;
        @(negedge clk); addr_in = 19'h40000; data_in = 16'h0D0D; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        hw_rst_n = 1'b0;
        idle(3);
        hw_rst_n = 1'b1;
        idle(4);
        ce_n = 1'b1; we_n = 1'b1;
        expect_events("R8 reset pin aborts", 0, 0, 0);
        @(negedge clk); hw_rst_n = 1'b0;
        bus_write(19'h40001, 16'h0E0E, 4);
        expect_events("R8 reset pin blocks", 0, 0, 0);
        hw_rst_n = 1'b1;
        idle(3);
        bus_write(19'h40002, 16'h0F0F, 4);
        expect_events("R8 resumes after release", 1, 19'h40002, 16'h0F0F);
    endtask

    initial begin
        t_reset();
        t_holdoff();
        t_latency();
        t_addr_order();
        t_data();
        t_glitch();
        t_oe();
        t_hwreset();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule